// File: doc/BRIEF.md
# Sliding-Window Majority Deglitch Filter

This block cleans a single-bit receive stream that arrives oversampled, typically five to ten samples per data bit. Each sample strobe pushes the newest raw sample into a window whose length is chosen at run time. A running count of the ones in the window is kept up to date as samples enter and leave. The filtered output is a majority vote over the window, so pulses shorter than half the window are suppressed.

Every filtered bit is also stored in one of two 32-bit rows that are used in ping-pong fashion. When a row has received 32 bits, the block switches writing to the other row, names the finished row as readable and raises a full flag. A consumer reads the finished row through a combinational read port and clears the flag with a one-cycle acknowledge.

Top module: `vote_deglitch`

## Requirements
- R1: After reset `clean_bit`, `row_full`, `fill_row` and `ready_row` are 0 and the write position is bit 0 of row 0.
- R2: The effective window length N is `win_len`, with 0 treated as 1. Samples older than the last N accepted ones never count.
- R3: On an accepted strobe the oldest sample leaves the window and `raw_bit` enters it. Before N samples have been accepted since the last clear, the window holds only the samples accepted so far.
- R4: One cycle after an accepted strobe, `clean_bit` is 1 exactly when the number of ones in the window exceeds N/2 with integer division (for example N=5 needs 3 ones and N=4 needs 3 ones).
- R5: In a cycle without a strobe, `clean_bit` and the buffer do not change.
- R6: With N=1, `clean_bit` equals the sample taken at the last accepted strobe.
- R7: A change of `win_len` between cycles empties the window and forces `clean_bit` to 0. A strobe in the cycle of that change is discarded and writes nothing to the buffer.
- R8: Each accepted strobe writes the new filtered bit into row `fill_row`, at bit position k for the k-th write into that row, counting from bit 0.
- R9: The 32nd write into a row returns the position to bit 0, toggles `fill_row`, sets `ready_row` to the row just completed and sets `row_full`.
- R10: `full_ack` clears `row_full` on the next edge. When it coincides with the 32nd write, `row_full` stays set.
- R11: `rd_word` combinationally shows the row selected by `rd_row` (0 or 1), with bit k being the k-th filtered bit written into that row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample strobe, one cycle per oversample |
| raw_bit | input | 1 | Raw receive sample |
| win_len | input | 4 | Window length, 1 to 15 (0 treated as 1) |
| full_ack | input | 1 | One-cycle acknowledge that clears `row_full` |
| rd_row | input | 1 | Row selected for the read port |
| clean_bit | output | 1 | Majority-voted data bit |
| rd_word | output | 32 | Contents of the selected row |
| fill_row | output | 1 | Row currently being written |
| ready_row | output | 1 | Row most recently completed |
| row_full | output | 1 | A completed row waits for the consumer |

## Verification
Two pairs of events can fall in the same cycle. The first is a window-length change together with a sample strobe. The bench drives both on one edge and then expects `clean_bit` at 0 and no buffer write; the write is judged by the later full flag, which must appear exactly 32 accepted strobes after the previous one. The second is the consumer acknowledge together with the 32nd write of a row. The bench waits until the model's write position reaches 31, asserts both together, and expects `row_full` to remain set while the rows swap.

// File: rtl/dglt_pkg.sv
package dglt_pkg;

  // Effective window length: zero is treated as one, anything above the maximum is capped.
  function automatic int clamp_len(input int w, input int maxw);
    if (w < 1) return 1;
    if (w > maxw) return maxw;
    return w;
  endfunction

  // Ones needed to exceed this value for a '1' vote.
  function automatic int vote_limit(input int n);
    return n / 2;
  endfunction

  // Flags of the ping-pong buffer.
  typedef struct packed {
    logic full;
    logic fill;
    logic ready;
  } pp_flags_t;

endpackage

// File: rtl/dglt_window.sv
module dglt_window
  import dglt_pkg::*;
#(
  parameter int MAXW = 15
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            stb,
  input  logic                            din,
  input  logic [$clog2(MAXW+1)-1:0]       len,
  output logic                            vote_o,
  output logic                            vote_next_o,
  output logic                            accept_o,
  output logic                            clear_o,
  output logic                            leave_o,
  output logic [$clog2(MAXW+2)-1:0]       cnt_o,
  output logic [MAXW:0]                   sh_o,
  output logic [$clog2(MAXW+1)-1:0]       eff_o
);

  localparam int SHW = MAXW + 1;
  localparam int LW  = $clog2(MAXW + 1);
  localparam int CW  = $clog2(MAXW + 2);
  localparam int IW  = $clog2(SHW);

  logic [LW-1:0]  len_q;
  logic [LW-1:0]  eff;
  logic [SHW-1:0] sh_q, sh_n, mask;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           vote_q, vote_n;
  logic           leave, clear, accept;

  always_comb begin
    eff = LW'(clamp_len(int'(len_q), MAXW));
    for (int i = 0; i < SHW; i++) begin
      mask[i] = (i < int'(eff));
    end
  end

  assign clear  = (len != len_q);
  assign accept = stb && !clear;
  assign leave  = sh_q[IW'(eff) - IW'(1)];

  always_comb begin
    cnt_n  = cnt_q - CW'(leave) + CW'(din);
    sh_n   = ((sh_q << 1) | SHW'(din)) & mask;
    vote_n = (cnt_n > CW'(vote_limit(int'(eff))));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q  <= '0;
      sh_q   <= '0;
      cnt_q  <= '0;
      vote_q <= 1'b0;
    end else if (clear) begin
      len_q  <= len;
      sh_q   <= '0;
      cnt_q  <= '0;
      vote_q <= 1'b0;
    end else if (accept) begin
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
      vote_q <= vote_n;
    end
  end

  assign vote_o      = vote_q;
  assign vote_next_o = vote_n;
  assign accept_o    = accept;
  assign clear_o     = clear;
  assign leave_o     = leave;
  assign cnt_o       = cnt_q;
  assign sh_o        = sh_q;
  assign eff_o       = eff;

endmodule

// File: rtl/dglt_pingpong.sv
module dglt_pingpong
  import dglt_pkg::*;
#(
  parameter int ROWW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            din,
  input  logic            ack,
  input  logic            rd_sel,
  output logic [ROWW-1:0] rd_word,
  output pp_flags_t       flags_o,
  output logic            wrap_o
);

  localparam int PW = $clog2(ROWW);

  logic [PW-1:0] ptr_q;
  pp_flags_t     fl_q;
  logic          wrap;
  logic [ROWW-1:0] row_word [2];

  assign wrap = wr && (ptr_q == PW'(ROWW - 1));

  for (genvar r = 0; r < 2; r++) begin : g_row
    logic [ROWW-1:0] bits_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bits_q <= '0;
      end else if (wr && (fl_q.fill == 1'(r))) begin
        bits_q[ptr_q] <= din;
      end
    end
    assign row_word[r] = bits_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      fl_q  <= '0;
    end else begin
      if (wr) begin
        ptr_q <= wrap ? '0 : ptr_q + PW'(1);
      end
      if (wrap) begin
        fl_q.fill  <= ~fl_q.fill;
        fl_q.ready <= fl_q.fill;
        fl_q.full  <= 1'b1;
      end else if (ack) begin
        fl_q.full  <= 1'b0;
      end
    end
  end

  assign rd_word = rd_sel ? row_word[1] : row_word[0];
  assign flags_o = fl_q;
  assign wrap_o  = wrap;

endmodule

// File: rtl/vote_deglitch.sv
module vote_deglitch
  import dglt_pkg::*;
#(
  parameter int MAXW = 15,
  parameter int ROWW = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_stb,
  input  logic                      raw_bit,
  input  logic [$clog2(MAXW+1)-1:0] win_len,
  input  logic                      full_ack,
  input  logic                      rd_row,
  output logic                      clean_bit,
  output logic [ROWW-1:0]           rd_word,
  output logic                      fill_row,
  output logic                      ready_row,
  output logic                      row_full
);

  localparam int LW = $clog2(MAXW + 1);
  localparam int CW = $clog2(MAXW + 2);

  // Internal events brought out for the checker.
  logic            win_accept;
  logic            win_clear;
  logic            leave_bit;
  logic            vote_next;
  logic            buf_wrap;
  logic [CW-1:0]   cnt_w;
  logic [MAXW:0]   sh_w;
  logic [LW-1:0]   eff_w;
  pp_flags_t       flags_w;

  dglt_window #(.MAXW(MAXW)) win_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (smp_stb),
    .din         (raw_bit),
    .len         (win_len),
    .vote_o      (clean_bit),
    .vote_next_o (vote_next),
    .accept_o    (win_accept),
    .clear_o     (win_clear),
    .leave_o     (leave_bit),
    .cnt_o       (cnt_w),
    .sh_o        (sh_w),
    .eff_o       (eff_w)
  );

  dglt_pingpong #(.ROWW(ROWW)) buf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (win_accept),
    .din     (vote_next),
    .ack     (full_ack),
    .rd_sel  (rd_row),
    .rd_word (rd_word),
    .flags_o (flags_w),
    .wrap_o  (buf_wrap)
  );

  assign fill_row  = flags_w.fill;
  assign ready_row = flags_w.ready;
  assign row_full  = flags_w.full;

endmodule

// File: rtl/vote_deglitch_chk.sv
module vote_deglitch_chk #(
  parameter int MAXW = 15
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      smp_stb,
  input logic                      raw_bit,
  input logic                      full_ack,
  input logic                      clean_bit,
  input logic                      fill_row,
  input logic                      ready_row,
  input logic                      row_full,
  input logic                      win_accept,
  input logic                      win_clear,
  input logic                      buf_wrap,
  input logic [$clog2(MAXW+2)-1:0] cnt_w,
  input logic [MAXW:0]             sh_w,
  input logic [$clog2(MAXW+1)-1:0] eff_w
);

  AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_w) == $countones(sh_w)); // R3

  AST_WIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_w >> eff_w) == '0); // R2

  AST_VOTE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    clean_bit == (int'(cnt_w) > int'(eff_w) / 2)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb && !win_clear) |=> $stable(clean_bit)); // R5

  AST_ECHO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_accept && eff_w == 1) |=> (clean_bit == $past(raw_bit))); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    win_clear |=> (clean_bit == 1'b0 && cnt_w == '0)); // R7

  AST_WRAP_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wrap |=> (row_full && ready_row == $past(fill_row) && fill_row != $past(fill_row))); // R9

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (full_ack && !buf_wrap) |=> !row_full); // R10

endmodule

bind vote_deglitch vote_deglitch_chk #(.MAXW(MAXW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_stb    (smp_stb),
  .raw_bit    (raw_bit),
  .full_ack   (full_ack),
  .clean_bit  (clean_bit),
  .fill_row   (fill_row),
  .ready_row  (ready_row),
  .row_full   (row_full),
  .win_accept (win_accept),
  .win_clear  (win_clear),
  .buf_wrap   (buf_wrap),
  .cnt_w      (cnt_w),
  .sh_w       (sh_w),
  .eff_w      (eff_w)
);

// File: tb/vote_deglitch_tb_top.sv
module vote_deglitch_tb_top;

  localparam int CLK_P = 10;

  typedef struct {
    logic clean;
    logic full;
    logic fill;
    logic ready;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_stb = 1'b0;
  logic        raw_bit = 1'b0;
  logic [3:0]  win_len = 4'd0;
  logic        full_ack = 1'b0;
  logic        rd_row = 1'b0;
  logic        clean_bit;
  logic [31:0] rd_word;
  logic        fill_row, ready_row, row_full;

  int n_chk = 0;
  int n_fail = 0;
  string phase = "R4";

  exp_t        exp_q[$];
  logic        hist[16];
  int          acc = 0;
  int          cur_n = 1;
  int          len_raw = 0;
  logic [31:0] exp_rows[2];
  int          exp_ptr = 0;
  logic        exp_fill = 1'b0;
  logic        exp_ready = 1'b0;
  logic        exp_full = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vote_deglitch dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .raw_bit(raw_bit),
    .win_len(win_len), .full_ack(full_ack), .rd_row(rd_row),
    .clean_bit(clean_bit), .rd_word(rd_word), .fill_row(fill_row),
    .ready_row(ready_row), .row_full(row_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Majority of the samples accepted since the last clear, restricted to the last N.
  function automatic logic model_vote(input int n);
    int ones = 0;
    int k = (acc < n) ? acc : n;
    for (int i = 0; i < k; i++) ones += int'(hist[i]);
    return (2 * ones > n);
  endfunction

  task automatic set_len(input int v);
    @(negedge clk);
    win_len = 4'(v);
    if (v != len_raw) begin
      acc = 0;
      len_raw = v;
      cur_n = (v < 1) ? 1 : v;
    end
  endtask

  // Window change and strobe in the same cycle: the sample is dropped (R7).
  task automatic set_len_with_strobe(input int v, input logic b);
    @(negedge clk);
    win_len = 4'(v);
    raw_bit = b;
    smp_stb = 1'b1;
    acc = 0;
    len_raw = v;
    cur_n = (v < 1) ? 1 : v;
    @(posedge clk);
    #1 smp_stb = 1'b0;
  endtask

  task automatic strobe(input logic b, input logic ack);
    exp_t e;
    @(negedge clk);
    raw_bit = b;
    smp_stb = 1'b1;
    full_ack = ack;
    for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = b;
    acc++;
    e.clean = model_vote(cur_n);
    exp_rows[exp_fill][exp_ptr] = e.clean;
    exp_ptr++;
    if (exp_ptr == 32) begin
      exp_ptr = 0;
      exp_ready = exp_fill;
      exp_fill = ~exp_fill;
      exp_full = 1'b1;
    end else if (ack) begin
      exp_full = 1'b0;
    end
    e.full = exp_full;
    e.fill = exp_fill;
    e.ready = exp_ready;
    exp_q.push_back(e);
    @(posedge clk);
    #1;
    smp_stb = 1'b0;
    full_ack = 1'b0;
  endtask

  // Monitor: compares each accepted strobe's result one half-cycle after the edge.
  always begin
    @(posedge clk);
    if (rst_n && smp_stb && exp_q.size() > 0) begin
      exp_t e;
      @(negedge clk);
      e = exp_q.pop_front();
      chk({phase, " clean_bit"}, 32'(clean_bit), 32'(e.clean));
      chk("R9 row_full", 32'(row_full), 32'(e.full));
      chk("R9 fill_row", 32'(fill_row), 32'(e.fill));
      chk("R9 ready_row", 32'(ready_row), 32'(e.ready));
    end
  end

  task automatic read_ready_row();
    @(negedge clk);
    rd_row = exp_ready;
    #1 chk("R11 R8 rd_word", rd_word, exp_rows[exp_ready]);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic held;
    logic [15:0] pat_a, pat_b;
    logic [9:0]  pat_e;
    logic [5:0]  pat_z;
    for (int i = 0; i < 16; i++) hist[i] = 1'b0;
    exp_rows[0] = '0;
    exp_rows[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 clean_bit", 32'(clean_bit), 0);
    chk("R1 row_full", 32'(row_full), 0);
    chk("R1 fill_row", 32'(fill_row), 0);
    chk("R1 ready_row", 32'(ready_row), 0);

    // R4 / R3 with N=5: glitches of one and two samples, then long runs
    set_len(5);
    @(negedge clk);
    phase = "R4";
    pat_a = 16'b1111_0010_0011_0111;
    for (int i = 0; i < 16; i++) strobe(pat_a[i], 1'b0);
    phase = "R3";
    pat_b = 16'b1101_1110_1100_0010;
    for (int i = 0; i < 16; i++) strobe(pat_b[i], 1'b0);
    // 32 writes done: row 0 complete (R9 checked by the monitor)
    read_ready_row();

    // R5: no strobe, raw input toggling, output must hold
    @(negedge clk);
    held = clean_bit;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      raw_bit = ~raw_bit;
      @(negedge clk);
      chk("R5 clean_bit hold", 32'(clean_bit), 32'(held));
    end
    chk("R5 rd_word hold", rd_word, exp_rows[exp_ready]);

    // R10: acknowledge alone clears the flag
    @(negedge clk) full_ack = 1'b1;
    @(posedge clk);
    #1 full_ack = 1'b0;
    exp_full = 1'b0;
    @(negedge clk);
    chk("R10 ack clears row_full", 32'(row_full), 0);

    // R6: N=1 echoes the sample
    set_len(1);
    phase = "R6";
    pat_e = 10'b10_0101_1001;
    for (int i = 0; i < 10; i++) strobe(pat_e[i], 1'b0);

    // R2: N=0 behaves as N=1
    set_len(0);
    phase = "R2";
    pat_z = 6'b01_0110;
    for (int i = 0; i < 6; i++) strobe(pat_z[i], 1'b0);

    // R7: length change coinciding with a strobe
    set_len_with_strobe(15, 1'b1);
    @(negedge clk);
    chk("R7 clean_bit after clear", 32'(clean_bit), 0);

    // R3 / R2 with N=15: window fill-up and long-term majority
    phase = "R3";
    for (int i = 0; i < 20; i++) strobe((i % 4) != 3, 1'b0);

    // run to the last slot of the row, then ack and wrap together (R10)
    phase = "R4";
    while (exp_ptr != 31) strobe((exp_ptr % 3) == 0, 1'b0);
    chk("R10 full before coincidence", 32'(row_full), 1);
    strobe(1'b0, 1'b1);
    @(negedge clk);
    chk("R10 wrap beats ack", 32'(row_full), 1);
    read_ready_row();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule